// File: doc/BRIEF.md
# Cache Line Maintenance Engine

This block owns the per-line state of a set-associative cache: a valid bit, a dirty bit, a lock bit and the line tag for every way of every set. It runs one explicit maintenance command at a time and accepts a new command only while it is idle. The commands are flush, invalidate and the atomic flush-and-invalidate. Each of the three can be aimed at one address, at one set index, or, for flush and invalidate, at the whole cache. The engine also handles locking and unlocking a line by address and prefetching a line by address. Dirty data leaves through a write-back request port, and new lines arrive through a fill request port. Both ports use a plain request/acknowledge pair.

The tag kept for each line is the full line address, meaning the address with its byte-offset bits removed. The set index is the low bits of that line address. The load/store pipeline uses two small hooks. One marks a resident line dirty after a store hit. The other probes a line's state. Locked lines are never replaced. A prefetch that finds no replaceable way is dropped without any effect. The engine reports a one-cycle flush event for every dirty line it flushes, and a one-cycle replacement event whenever a prefetch displaces a valid line.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset, busy, done, wb_req, fill_req, flush_evt and repl_evt are low and every line is invalid, so a probe of any address misses.
- R2: Flush (op code 0) at address scope (scope code 0) acts only on a resident, dirty line. It raises one write-back whose wb_addr is the line base address, with the offset bits zero, and holds wb_addr until wb_ack. After that the line stays valid with its lock bit kept, its dirty bit is cleared, and flush_evt pulses for one cycle. A resident clean line causes no request.
- R3: Invalidate (op code 1) clears the valid, dirty and lock bits of the matching line. It never raises a write-back, even when the line is dirty.
- R4: Flush-and-invalidate (op code 2) writes a dirty line back and then makes it invalid. It does this as one command, during which no other command is taken.
- R5: Set scope (scope code 1, with the set taken from cmd_set) visits the ways of that set in ascending order. Whole-cache scope (scope code 2) visits sets in ascending order and, within each set, ways in ascending order. Write-backs follow that order. A line that needs no write-back takes one cycle. done follows the last line, so a pass with no dirty line ends WAYS+1 or SETS*WAYS+1 cycles after acceptance.
- R6: Each of the following raises done exactly 2 cycles after acceptance, with no bus request and no change of state: an address-scope command whose line is not resident, flush-and-invalidate with whole-cache scope, and any maintenance command with scope code 3.
- R7: Lock (op code 3) and unlock (op code 4) use the address and ignore the scope. They set or clear the lock bit of a resident line, and a probe reports that bit.
- R8: On a miss, prefetch (op code 5) picks its victim as follows. It takes the lowest-numbered invalid way if there is one. Otherwise it takes the first unlocked way found by scanning upward, with wrap-around, from the set's rotation pointer. After the fill, the pointer becomes victim+1. A dirty victim is written back before fill_req rises. repl_evt pulses when the victim was valid. fill_addr is the line base address. After fill_ack the line is valid, clean and unlocked.
- R9: A prefetch that hits, or that misses in a set whose ways are all locked, raises no request, changes nothing and completes 2 cycles after acceptance.
- R10: Mark-dirty (op code 6) sets the dirty bit of a resident line. Probe (op code 7) returns hit, dirty and lock on probe_hit, probe_dirty and probe_lock by the time done rises, and holds them until the next probe. Dirty and lock read as zero on a miss.
- R11: cmd_valid is sampled only while busy is low, so a command offered while busy is ignored. busy is high from the cycle after acceptance until the cycle in which done pulses for one cycle with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered (taken only while idle) |
| cmd_op | input | 3 | Operation code |
| cmd_scope | input | 2 | Target scope for maintenance operations |
| cmd_addr | input | ADDR_W | Byte address of the target line |
| cmd_set | input | SET_W | Set index for set scope |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| probe_hit | output | 1 | Last probe found the line |
| probe_dirty | output | 1 | Last probed line was dirty |
| probe_lock | output | 1 | Last probed line was locked |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Base address of the line being written back |
| wb_ack | input | 1 | Write-back accepted |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | ADDR_W | Base address of the line being filled |
| fill_ack | input | 1 | Fill completed |
| flush_evt | output | 1 | Pulse per flushed dirty line |
| repl_evt | output | 1 | Pulse when a prefetch displaces a valid line |

## Verification
The directed cases build lines that are clean, dirty, locked or absent, and then aim each command at them. This separates a flush, which keeps the line, from an invalidate, which drops the line without a write-back, and from flush-and-invalidate, which does both. Set and whole-cache passes run over caches with dirty lines scattered across them, so the order of the write-back addresses shows the walk order. Passes over clean caches expose the one-line-per-cycle timing through the done cycle. Prefetch runs into sets that have free ways, dirty victims, and every way locked, which tells the victim rule, write-back-before-fill ordering and silent drop apart. A long seeded random mix of all eight operations and four scopes, checked against a bench model with varying acknowledge delays, covers the combinations the directed cases miss.

// File: rtl/cme_pkg.sv
package cme_pkg;

    typedef enum logic [2:0] {
        OP_FLUSH    = 3'd0,
        OP_INVAL    = 3'd1,
        OP_FLINV    = 3'd2,
        OP_LOCK     = 3'd3,
        OP_UNLOCK   = 3'd4,
        OP_PREFETCH = 3'd5,
        OP_MARK     = 3'd6,
        OP_PROBE    = 3'd7
    } cme_op_e;

    typedef enum logic [1:0] {
        SC_ADDR = 2'd0,
        SC_SET  = 2'd1,
        SC_ALL  = 2'd2,
        SC_RSVD = 2'd3
    } cme_scope_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_EXEC = 2'd1,
        PH_WB   = 2'd2,
        PH_FILL = 2'd3
    } cme_phase_e;

endpackage

// File: rtl/cme_hit_find.sv
module cme_hit_find #(
    parameter  int WAYS  = 2,
    parameter  int TAG_W = 28,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
    input  logic [TAG_W-1:0]            key_i,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            way_o
);

    logic found;

    // Lowest matching way wins; a correct cache holds at most one match.
    always_comb begin
        found = 1'b0;
        way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && vld_i[w] && tag_i[w] == key_i) begin
                found = 1'b1;
                way_o = WAY_W'(w);
            end
        end
        hit_o = found;
    end

endmodule

// File: rtl/cme_victim_pick.sv
module cme_victim_pick #(
    parameter  int WAYS  = 2,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  vld_i,
    input  logic [WAYS-1:0]  lck_i,
    input  logic [WAY_W-1:0] ptr_i,
    output logic             found_o,
    output logic [WAY_W-1:0] way_o
);

    logic             found;
    logic [WAY_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        way_o = '0;
        idx   = '0;
        // First choice: a free way, lowest index.
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !vld_i[w] && !lck_i[w]) begin
                found = 1'b1;
                way_o = WAY_W'(w);
            end
        end
        // Otherwise: first unlocked way at or after the rotation pointer.
        for (int k = 0; k < WAYS; k++) begin
            idx = ptr_i + WAY_W'(k);
            if (!found && !lck_i[idx]) begin
                found = 1'b1;
                way_o = idx;
            end
        end
        found_o = found;
    end

endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
    import cme_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_BYTES = 16,
    parameter  int SETS       = 4,
    parameter  int WAYS       = 2,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int SET_W      = $clog2(SETS),
    localparam int WAY_W      = $clog2(WAYS),
    localparam int TAG_W      = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_scope,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SET_W-1:0]  cmd_set,
    output logic              busy,
    output logic              done,
    output logic              probe_hit,
    output logic              probe_dirty,
    output logic              probe_lock,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack,
    output logic              flush_evt,
    output logic              repl_evt
);

    typedef struct packed {
        cme_phase_e                          ph;
        cme_op_e                             op;
        cme_scope_e                          sc;
        logic [TAG_W-1:0]                    ltag;
        logic [SET_W-1:0]                    set;
        logic [WAY_W-1:0]                    way;
        logic [SETS-1:0][WAYS-1:0]           v;
        logic [SETS-1:0][WAYS-1:0]           d;
        logic [SETS-1:0][WAYS-1:0]           l;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] t;
        logic [SETS-1:0][WAY_W-1:0]          rr;
        logic                                done;
        logic                                fevt;
        logic                                revt;
        logic                                phit;
        logic                                pdirty;
        logic                                plock;
    } cme_state_t;

    cme_state_t s_q, s_d;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             vic_found;
    logic [WAY_W-1:0] vic_way;
    logic [WAY_W-1:0] tw;
    logic             line_on;
    logic             step_last;
    logic             go_next;
    logic             go_fin;
    logic             bad_scope;
    logic             in_maint;
    logic             unused_off;

    assign unused_off = ^cmd_addr[OFF_W-1:0];

    cme_hit_find #(.WAYS(WAYS), .TAG_W(TAG_W)) i_hit (
        .vld_i (s_q.v[s_q.set]),
        .tag_i (s_q.t[s_q.set]),
        .key_i (s_q.ltag),
        .hit_o (hit),
        .way_o (hit_way)
    );

    cme_victim_pick #(.WAYS(WAYS)) i_vic (
        .vld_i   (s_q.v[s_q.set]),
        .lck_i   (s_q.l[s_q.set]),
        .ptr_i   (s_q.rr[s_q.set]),
        .found_o (vic_found),
        .way_o   (vic_way)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.fevt  = 1'b0;
        s_d.revt  = 1'b0;
        go_next   = 1'b0;
        go_fin    = 1'b0;
        in_maint  = (cmd_op <= 3'd2);
        tw        = (s_q.sc == SC_ADDR) ? hit_way : s_q.way;
        line_on   = (s_q.sc == SC_ADDR) ? hit : s_q.v[s_q.set][s_q.way];
        bad_scope = (s_q.sc == SC_RSVD) || (s_q.op == OP_FLINV && s_q.sc == SC_ALL);
        step_last = (s_q.sc == SC_ADDR) ||
                    (s_q.way == WAY_W'(WAYS - 1) &&
                     (s_q.sc == SC_SET || s_q.set == SET_W'(SETS - 1)));

        unique case (s_q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    s_d.ph   = PH_EXEC;
                    s_d.op   = cme_op_e'(cmd_op);
                    s_d.sc   = in_maint ? cme_scope_e'(cmd_scope) : SC_ADDR;
                    s_d.ltag = cmd_addr[ADDR_W-1:OFF_W];
                    s_d.way  = '0;
                    if (in_maint && cmd_scope == 2'd1)
                        s_d.set = cmd_set;
                    else if (in_maint && cmd_scope == 2'd2)
                        s_d.set = '0;
                    else
                        s_d.set = cmd_addr[OFF_W +: SET_W];
                end
            end

            PH_EXEC: begin
                unique case (s_q.op)
                    OP_FLUSH, OP_INVAL, OP_FLINV: begin
                        s_d.way = tw;
                        if (bad_scope) begin
                            go_fin = 1'b1;
                        end else if (!line_on) begin
                            go_next = 1'b1;
                        end else if (s_q.op != OP_INVAL && s_q.d[s_q.set][tw]) begin
                            s_d.ph = PH_WB;
                        end else begin
                            if (s_q.op != OP_FLUSH) begin
                                s_d.v[s_q.set][tw] = 1'b0;
                                s_d.d[s_q.set][tw] = 1'b0;
                                s_d.l[s_q.set][tw] = 1'b0;
                            end
                            go_next = 1'b1;
                        end
                    end
                    OP_LOCK: begin
                        if (hit) s_d.l[s_q.set][hit_way] = 1'b1;
                        go_fin = 1'b1;
                    end
                    OP_UNLOCK: begin
                        if (hit) s_d.l[s_q.set][hit_way] = 1'b0;
                        go_fin = 1'b1;
                    end
                    OP_MARK: begin
                        if (hit) s_d.d[s_q.set][hit_way] = 1'b1;
                        go_fin = 1'b1;
                    end
                    OP_PROBE: begin
                        s_d.phit   = hit;
                        s_d.pdirty = hit && s_q.d[s_q.set][hit_way];
                        s_d.plock  = hit && s_q.l[s_q.set][hit_way];
                        go_fin     = 1'b1;
                    end
                    default: begin // prefetch
                        if (hit || !vic_found) begin
                            go_fin = 1'b1;
                        end else begin
                            s_d.way  = vic_way;
                            s_d.revt = s_q.v[s_q.set][vic_way];
                            if (s_q.v[s_q.set][vic_way] && s_q.d[s_q.set][vic_way])
                                s_d.ph = PH_WB;
                            else
                                s_d.ph = PH_FILL;
                        end
                    end
                endcase
            end

            PH_WB: begin
                if (wb_ack) begin
                    if (s_q.op == OP_PREFETCH) begin
                        s_d.ph = PH_FILL;
                    end else begin
                        s_d.d[s_q.set][s_q.way] = 1'b0;
                        s_d.fevt = 1'b1;
                        if (s_q.op == OP_FLINV) begin
                            s_d.v[s_q.set][s_q.way] = 1'b0;
                            s_d.l[s_q.set][s_q.way] = 1'b0;
                        end
                        s_d.ph  = PH_EXEC;
                        go_next = 1'b1;
                    end
                end
            end

            default: begin // PH_FILL
                if (fill_ack) begin
                    s_d.t[s_q.set][s_q.way] = s_q.ltag;
                    s_d.v[s_q.set][s_q.way] = 1'b1;
                    s_d.d[s_q.set][s_q.way] = 1'b0;
                    s_d.l[s_q.set][s_q.way] = 1'b0;
                    s_d.rr[s_q.set]         = s_q.way + WAY_W'(1);
                    go_fin                  = 1'b1;
                end
            end
        endcase

        if (go_next) begin
            if (step_last) begin
                go_fin = 1'b1;
            end else if (s_q.way == WAY_W'(WAYS - 1)) begin
                s_d.way = '0;
                s_d.set = s_q.set + SET_W'(1);
            end else begin
                s_d.way = s_q.way + WAY_W'(1);
            end
        end

        if (go_fin) begin
            s_d.ph   = PH_IDLE;
            s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy        = (s_q.ph != PH_IDLE);
    assign done        = s_q.done;
    assign probe_hit   = s_q.phit;
    assign probe_dirty = s_q.pdirty;
    assign probe_lock  = s_q.plock;
    assign wb_req      = (s_q.ph == PH_WB);
    assign wb_addr     = {s_q.t[s_q.set][s_q.way], {OFF_W{1'b0}}};
    assign fill_req    = (s_q.ph == PH_FILL);
    assign fill_addr   = {s_q.ltag, {OFF_W{1'b0}}};
    assign flush_evt   = s_q.fevt;
    assign repl_evt    = s_q.revt;

endmodule

// File: rtl/cme_checker.sv
module cme_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ack,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_ack,
    input logic              flush_evt,
    input logic              repl_evt
);

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wb_req && !fill_req)); // R11

    AST_SINGLE_BUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && fill_req)); // R8

    AST_WB_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr))); // R2

    AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr))); // R8

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_FLUSH_EVT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        flush_evt |-> $past(wb_req && wb_ack)); // R2

    AST_REPL_INSIDE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        repl_evt |-> (busy && (wb_req || fill_req))); // R8

endmodule

bind cache_maint_engine cme_checker #(.ADDR_W(ADDR_W)) i_cme_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .wb_req    (wb_req),
    .wb_addr   (wb_addr),
    .wb_ack    (wb_ack),
    .fill_req  (fill_req),
    .fill_addr (fill_addr),
    .fill_ack  (fill_ack),
    .flush_evt (flush_evt),
    .repl_evt  (repl_evt)
);

// File: tb/test_cache_maint_engine.sv
module test_cache_maint_engine;

    localparam int NS = 4;
    localparam int NW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_scope = '0;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_set = '0;
    logic        busy, done, probe_hit, probe_dirty, probe_lock;
    logic        wb_req, fill_req, flush_evt, repl_evt;
    logic [31:0] wb_addr, fill_addr;
    logic        wb_ack = 1'b0;
    logic        fill_ack = 1'b0;

    always #2 clk = ~clk;

    cache_maint_engine i_cache_maint_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_scope(cmd_scope), .cmd_addr(cmd_addr), .cmd_set(cmd_set),
        .busy(busy), .done(done), .probe_hit(probe_hit), .probe_dirty(probe_dirty),
        .probe_lock(probe_lock), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack),
        .flush_evt(flush_evt), .repl_evt(repl_evt)
    );

    int n_chk = 0;
    int n_fail = 0;
    int slow = 0;

    // bench model of the line state
    bit m_v[NS][NW];
    bit m_d[NS][NW];
    bit m_l[NS][NW];
    int m_t[NS][NW];
    int m_rr[NS];

    int exp_wb[$];
    int exp_fill[$];
    int got_wb[$];
    int got_fill[$];
    int exp_fevt, exp_revt, got_fevt, got_revt, exp_cyc;
    bit exp_ph, exp_pd, exp_pl;

    task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int la(int tg, int st, int off);
        return (((tg << 2) | st) << 4) | off;
    endfunction

    function automatic int find_way(int s, int line);
        for (int w = 0; w < NW; w++)
            if (m_v[s][w] && m_t[s][w] == line) return w;
        return -1;
    endfunction

    function automatic bit same_q(int a[$], int b[$]);
        if (a.size() != b.size()) return 1'b0;
        for (int i = 0; i < a.size(); i++)
            if (a[i] != b[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic void clr_line(int s, int w);
        m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_l[s][w] = 1'b0;
    endfunction

    function automatic void model(int op, int sc, int addr, int cset);
        int line, s, h, vw, first, last;
        line = addr >> 4;
        s    = line % NS;
        exp_wb.delete(); exp_fill.delete();
        exp_fevt = 0; exp_revt = 0; exp_cyc = -1;
        h = find_way(s, line);
        if (op <= 2) begin
            if (sc == 3 || (op == 2 && sc == 2)) begin exp_cyc = 2; return; end
            if (sc == 0) begin
                if (h < 0) begin exp_cyc = 2; return; end
                first = s * NW + h; last = first;
            end else if (sc == 1) begin
                first = cset * NW; last = first + NW - 1;
            end else begin
                first = 0; last = NS * NW - 1;
            end
            for (int i = first; i <= last; i++) begin
                int ss, ww;
                ss = i / NW; ww = i % NW;
                if (!m_v[ss][ww]) continue;
                if (op != 1 && m_d[ss][ww]) begin
                    exp_wb.push_back(m_t[ss][ww] << 4);
                    exp_fevt++;
                    m_d[ss][ww] = 1'b0;
                end
                if (op != 0) clr_line(ss, ww);
            end
            if (exp_wb.size() == 0) exp_cyc = (sc == 0) ? 2 : (sc == 1) ? NW + 1 : NS * NW + 1;
        end else if (op == 5) begin
            exp_cyc = 2;
            if (h >= 0) return;
            vw = -1;
            for (int w = 0; w < NW; w++) if (vw < 0 && !m_v[s][w] && !m_l[s][w]) vw = w;
            for (int k = 0; k < NW; k++) begin
                int w;
                w = (m_rr[s] + k) % NW;
                if (vw < 0 && !m_l[s][w]) vw = w;
            end
            if (vw < 0) return;
            exp_cyc = -1;
            if (m_v[s][vw]) begin
                exp_revt = 1;
                if (m_d[s][vw]) exp_wb.push_back(m_t[s][vw] << 4);
            end
            exp_fill.push_back(line << 4);
            m_v[s][vw] = 1'b1; m_d[s][vw] = 1'b0; m_l[s][vw] = 1'b0;
            m_t[s][vw] = line;
            m_rr[s] = (vw + 1) % NW;
        end else begin
            exp_cyc = 2;
            if (op == 7) begin
                exp_ph = (h >= 0);
                exp_pd = (h >= 0) && m_d[s][h];
                exp_pl = (h >= 0) && m_l[s][h];
            end else if (h >= 0) begin
                if (op == 3) m_l[s][h] = 1'b1;
                if (op == 4) m_l[s][h] = 1'b0;
                if (op == 6) m_d[s][h] = 1'b1;
            end
        end
    endfunction

    task automatic run(input int op, input int sc, input int addr, input int cset,
                       input string req, input bit poke = 1'b0, input int paddr = 0);
        int n;
        model(op, sc, addr, cset);
        got_wb.delete(); got_fill.delete();
        got_fevt = 0; got_revt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_scope = 2'(sc);
        cmd_addr = 32'(addr); cmd_set = 2'(cset);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) cmd_valid = 1'b0;
            if (poke && n == 2) begin
                chk(req, busy == 1'b1, "busy while second command offered", int'(busy), 1);
                cmd_valid = 1'b1; cmd_op = 3'd6; cmd_scope = 2'd0; cmd_addr = 32'(paddr);
            end
            if (poke && n == 3) cmd_valid = 1'b0;
        end while (!done && n < 600);
        chk(req, done == 1'b1, "done seen", int'(done), 1);
        @(negedge clk);
        chk(req, same_q(got_wb, exp_wb), "write-back sequence (count)", got_wb.size(), exp_wb.size());
        chk(req, same_q(got_fill, exp_fill), "fill sequence (count)", got_fill.size(), exp_fill.size());
        chk(req, got_fevt == exp_fevt, "flush events", got_fevt, exp_fevt);
        chk(req, got_revt == exp_revt, "replacement events", got_revt, exp_revt);
        if (exp_cyc >= 0) chk(req, n == exp_cyc, "cycles to done", n, exp_cyc);
        if (op == 7) begin
            chk(req, probe_hit == exp_ph, "probe hit", int'(probe_hit), int'(exp_ph));
            chk(req, probe_dirty == exp_pd, "probe dirty", int'(probe_dirty), int'(exp_pd));
            chk(req, probe_lock == exp_pl, "probe lock", int'(probe_lock), int'(exp_pl));
        end
    endtask

    // downstream memory responder
    initial begin
        int wd, fd;
        wd = 0; fd = 0;
        forever begin
            @(negedge clk);
            if (wb_ack) wb_ack = 1'b0;
            else if (wb_req) begin
                if (wd > 0) wd--;
                else begin
                    wb_ack = 1'b1;
                    got_wb.push_back(int'(wb_addr));
                    wd = int'($urandom_range(0, 3)) + slow;
                end
            end
            if (fill_ack) fill_ack = 1'b0;
            else if (fill_req) begin
                if (fd > 0) fd--;
                else begin
                    fill_ack = 1'b1;
                    got_fill.push_back(int'(fill_addr));
                    fd = int'($urandom_range(0, 3));
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (flush_evt) got_fevt++;
            if (repl_evt) got_revt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", busy == 1'b0, "busy after reset", int'(busy), 0);
        chk("R1", done == 1'b0, "done after reset", int'(done), 0);
        chk("R1", wb_req == 1'b0 && fill_req == 1'b0, "bus requests after reset", int'(wb_req | fill_req), 0);
        chk("R1", flush_evt == 1'b0 && repl_evt == 1'b0, "events after reset", int'(flush_evt | repl_evt), 0);
        run(7, 0, la(0, 0, 0), 0, "R1");

        // R8 / R10: fill, probe, mark dirty
        run(5, 0, la(1, 0, 3), 0, "R8");
        run(7, 0, la(1, 0, 0), 0, "R10");
        run(6, 0, la(1, 0, 9), 0, "R10");
        run(7, 0, la(1, 0, 0), 0, "R10");
        // R2: flush keeps the line valid and clean
        run(0, 0, la(1, 0, 5), 0, "R2");
        run(7, 0, la(1, 0, 0), 0, "R2");
        run(0, 0, la(1, 0, 5), 0, "R2");
        // R3: invalidate a dirty line, no write-back
        run(6, 0, la(1, 0, 0), 0, "R3");
        run(1, 0, la(1, 0, 0), 0, "R3");
        run(7, 0, la(1, 0, 0), 0, "R3");
        // R4: flush-and-invalidate
        run(5, 0, la(2, 1, 0), 0, "R4");
        run(6, 0, la(2, 1, 0), 0, "R4");
        run(2, 0, la(2, 1, 4), 0, "R4");
        run(7, 0, la(2, 1, 0), 0, "R4");
        // R6: absent line, unsupported scope combinations
        run(3, 0, la(7, 3, 0), 0, "R6");
        run(0, 0, la(7, 3, 0), 0, "R6");
        run(5, 0, la(3, 2, 0), 0, "R6");
        run(6, 0, la(3, 2, 0), 0, "R6");
        run(2, 2, 0, 0, "R6");
        run(0, 3, la(3, 2, 0), 2, "R6");
        run(7, 0, la(3, 2, 0), 0, "R6");
        // R7 / R9 / R8: locking and replacement
        run(5, 0, la(4, 1, 0), 0, "R8");
        run(5, 0, la(5, 1, 0), 0, "R8");
        run(6, 0, la(4, 1, 0), 0, "R7");
        run(6, 0, la(5, 1, 0), 0, "R7");
        run(3, 2, la(4, 1, 0), 3, "R7");
        run(3, 0, la(5, 1, 0), 0, "R7");
        run(7, 0, la(4, 1, 0), 0, "R7");
        run(5, 0, la(6, 1, 0), 0, "R9");
        run(4, 0, la(4, 1, 0), 0, "R7");
        run(7, 0, la(4, 1, 0), 0, "R7");
        run(5, 0, la(6, 1, 0), 0, "R8");
        run(5, 0, la(6, 1, 0), 0, "R9");
        run(7, 0, la(5, 1, 0), 0, "R7");
        // R5: set and whole-cache walks
        run(5, 0, la(1, 3, 0), 0, "R5");
        run(5, 0, la(2, 3, 0), 0, "R5");
        run(6, 0, la(1, 3, 0), 0, "R5");
        run(6, 0, la(2, 3, 0), 0, "R5");
        run(6, 0, la(6, 1, 0), 0, "R5");
        run(0, 1, 0, 3, "R5");
        run(0, 1, 0, 3, "R5");
        run(6, 0, la(2, 3, 0), 0, "R5");
        run(6, 0, la(3, 2, 0), 0, "R5");
        run(0, 2, 0, 0, "R5");
        run(0, 2, 0, 0, "R5");
        run(1, 1, 0, 1, "R5");
        run(1, 2, 0, 0, "R5");
        run(1, 2, 0, 0, "R5");
        // R11: command offered while busy is ignored
        run(5, 0, la(1, 3, 0), 0, "R11");
        run(5, 0, la(2, 3, 0), 0, "R11");
        run(6, 0, la(1, 3, 0), 0, "R11");
        slow = 6;
        run(0, 0, la(1, 3, 0), 0, "R11", 1'b1, la(2, 3, 0));
        slow = 0;
        run(7, 0, la(2, 3, 0), 0, "R11");

        // seeded random mix over a small address pool
        for (int i = 0; i < 500; i++) begin
            int op, sc, a, cs;
            op = int'($urandom_range(0, 7));
            sc = int'($urandom_range(0, 3));
            a  = la(int'($urandom_range(0, 5)), int'($urandom_range(0, 3)), int'($urandom_range(0, 15)));
            cs = int'($urandom_range(0, 3));
            case (op)
                0: run(op, sc, a, cs, "R2");
                1: run(op, sc, a, cs, "R3");
                2: run(op, sc, a, cs, "R4");
                3, 4: run(op, sc, a, cs, "R7");
                5: run(op, sc, a, cs, "R8");
                default: run(op, sc, a, cs, "R10");
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule